// File: doc/BRIEF.md
# Pulse Tone Voice

This block is one square-wave tone voice for a sound unit. Software programs it through five byte-wide registers. The registers set the duty cycle, an 11-bit frequency, a length counter, a volume envelope and a frequency sweep. A write with the restart bit set starts the voice. The voice then produces a 4-bit amplitude and an active flag.

The block derives three slow clocks from the system clock: a length clock, an envelope clock and a sweep clock. A divider produces a frame step every `FRAME_DIV` clocks, and the slow clocks are taken from steps of that sequence.

- The length clock runs every 2 frame steps.
- The sweep clock runs every 4 frame steps.
- The envelope clock runs every 8 frame steps.

Register indices on `regAddr` are:

| Index | Register |
|-------|----------|
| 0 | Sweep |
| 1 | Duty/length |
| 2 | Envelope |
| 3 | Frequency low |
| 4 | Frequency high / control |

Top module: `squareVoice`

## Requirements
- R1: After reset, `amp` is 0 and `active` is 0.
- R2: Writing index 4 with bit 7 set does four things. It sets `active` on the next clock, restarts the duty sequence at position 0, loads the volume from the envelope initial value, and uses the frequency including the high bits written in the same cycle.
- R3: The duty sequence has positions 0 to 7. The output is high while the position is below a threshold set by index 1 bits 7-6: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6. `amp` equals the volume while the output is high and the voice is active, and is 0 otherwise.
- R4: Each duty position lasts (2048 - f) * 4 clocks. The frequency f is index 4 bits 2-0 above index 3 bits 7-0.
- R5: Reads return the following values.
  - Index 0 reads as {1, bits 6-0 written}.
  - Index 1 reads as {duty, 6'b111111}.
  - Index 2 reads back as written.
  - Index 3 reads as 8'hFF.
  - Index 4 reads as {1, mode bit, 6'b111111}.
  - Unused indices read as 8'hFF.
- R6: A write to index 1 loads its bits 5-0 into the length counter. When index 4 bit 6 is 1, the counter steps up on each length clock while the voice is active, and clears `active` when it steps past 63. When index 4 bit 6 is 0, the length never stops the voice.
- R7: Index 2 holds the envelope settings: initial volume in bits 7-4, direction in bit 3 (1 = up), and period in bits 2-0. The volume moves by one every `period` envelope clocks and stops at 0 and at 15. A period of 0 holds the volume. Outside a restart, the volume never changes by more than one per clock.
- R8: Index 0 holds the sweep settings: time in bits 6-4, counted in sweep clocks; direction in bit 3 (0 = up); shift in bits 2-0. On each sweep, an upward step computes f + (f >> shift). If that sum exceeds 2047, `active` is cleared.
- R9: A downward sweep replaces f with f - (f >> shift). A shift of 0 leaves f unchanged. A sweep time of 0 performs no sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regAddr` (combinational) |
| amp | output | 4 | Digital amplitude |
| active | output | 1 | Voice enabled flag |

## Verification
The assertions assume three things about the inputs:
- `regAddr` and `wrData` are valid whenever `wrEn` is high.
- A restart is the only event that may move the volume by more than one step.
- Reset is held low before the first checked edge.

The stimulus changes inputs only at falling edges and makes one write per cycle, to indices 0 to 4 only. Frequencies in the random part are drawn close to the top of the range so that whole duty cycles stay short. The envelope and sweep are switched off during the random trials, so the amplitude sums are exact. In the slow-clock tests, each check is placed so that it holds for every phase of the frame divider relative to the restart.

// File: rtl/sqPkg.sv
package sqPkg;
  localparam int FREQ_W = 11;

  typedef struct packed {
    logic trigger;
    logic lenLoad;
    logic freqLoWr;
    logic freqHiWr;
    logic lenTick;
    logic envTick;
    logic sweepTick;
  } sqStrobe_t;

  typedef struct packed {
    logic [1:0] duty;
    logic       counterMode;
    logic [3:0] envInit;
    logic       envUp;
    logic [2:0] envPeriod;
    logic [2:0] sweepTime;
    logic       sweepDown;
    logic [2:0] sweepShift;
  } sqCfg_t;
endpackage

// File: rtl/sqControl.sv
module sqControl
  import sqPkg::*;
#(
  parameter int FRAME_DIV = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output sqCfg_t     cfg,
  output sqStrobe_t  strb
);
  localparam int DIV_W = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FRAME_DIV - 1);

  logic [6:0]       sweepReg;
  logic [1:0]       dutyReg;
  logic [7:0]       envReg;
  logic             modeReg;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       frameStep;
  logic             frameTick;

  assign frameTick = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepReg  <= '0;
      dutyReg   <= '0;
      envReg    <= '0;
      modeReg   <= 1'b0;
      divCnt    <= '0;
      frameStep <= '0;
    end else begin
      if (frameTick) begin
        divCnt    <= '0;
        frameStep <= frameStep + 3'd1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (wrEn) begin
        case (regAddr)
          3'd0: sweepReg <= wrData[6:0];
          3'd1: dutyReg  <= wrData[7:6];
          3'd2: envReg   <= wrData;
          3'd4: modeReg  <= wrData[6];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.trigger   = wrEn && (regAddr == 3'd4) && wrData[7];
    strb.lenLoad   = wrEn && (regAddr == 3'd1);
    strb.freqLoWr  = wrEn && (regAddr == 3'd3);
    strb.freqHiWr  = wrEn && (regAddr == 3'd4);
    strb.lenTick   = frameTick && !frameStep[0];
    strb.sweepTick = frameTick && (frameStep[1:0] == 2'd2);
    strb.envTick   = frameTick && (frameStep == 3'd7);
  end

  always_comb begin
    cfg.duty        = dutyReg;
    cfg.counterMode = modeReg;
    cfg.envInit     = envReg[7:4];
    cfg.envUp       = envReg[3];
    cfg.envPeriod   = envReg[2:0];
    cfg.sweepTime   = sweepReg[6:4];
    cfg.sweepDown   = sweepReg[3];
    cfg.sweepShift  = sweepReg[2:0];
  end

  always_comb begin
    case (regAddr)
      3'd0:    rdData = {1'b1, sweepReg};
      3'd1:    rdData = {dutyReg, 6'h3F};
      3'd2:    rdData = envReg;
      3'd4:    rdData = {1'b1, modeReg, 6'h3F};
      default: rdData = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sqDatapath.sv
module sqDatapath
  import sqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sqStrobe_t  strb,
  input  sqCfg_t     cfg,
  input  logic [7:0] wrData,
  output logic [3:0] amp,
  output logic       active,
  output logic [3:0] curVol
);
  localparam int TMR_W = FREQ_W + 3;

  logic [FREQ_W-1:0] freq, freqNext, delta, diff;
  logic [FREQ_W:0]   sum;
  logic [TMR_W-1:0]  timer, periodNext;
  logic [2:0]        pos, envTimer, sweepTimer;
  logic [5:0]        lenCnt;
  logic [3:0]        vol, highCnt;
  logic              sweepFire, sweepOvf, envFire;

  assign delta     = freq >> cfg.sweepShift;
  assign sum       = {1'b0, freq} + {1'b0, delta};
  assign diff      = freq - delta;
  assign sweepFire = !strb.trigger && strb.sweepTick && (cfg.sweepTime != 3'd0)
                     && (sweepTimer <= 3'd1);
  assign sweepOvf  = sweepFire && (cfg.sweepShift != 3'd0) && !cfg.sweepDown && sum[FREQ_W];
  assign envFire   = !strb.trigger && strb.envTick && (cfg.envPeriod != 3'd0)
                     && (envTimer <= 3'd1);

  always_comb begin
    freqNext = freq;
    if (sweepFire && (cfg.sweepShift != 3'd0) && !sweepOvf)
      freqNext = cfg.sweepDown ? diff : sum[FREQ_W-1:0];
    if (strb.freqLoWr) freqNext[7:0] = wrData;
    if (strb.freqHiWr) freqNext[FREQ_W-1:8] = wrData[FREQ_W-9:0];
  end

  assign periodNext = TMR_W'((12'd2048 - {1'b0, freqNext}) << 2);

  always_comb begin
    case (cfg.duty)
      2'b00:   highCnt = 4'd1;
      2'b01:   highCnt = 4'd2;
      2'b10:   highCnt = 4'd4;
      default: highCnt = 4'd6;
    endcase
  end

  assign amp    = (active && ({1'b0, pos} < highCnt)) ? vol : 4'd0;
  assign curVol = vol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freq       <= '0;
      timer      <= '0;
      pos        <= '0;
      lenCnt     <= '0;
      vol        <= '0;
      envTimer   <= '0;
      sweepTimer <= '0;
      active     <= 1'b0;
    end else begin
      freq <= freqNext;
      if (strb.trigger) begin
        timer <= periodNext;
        pos   <= '0;
      end else if (timer <= TMR_W'(1)) begin
        timer <= periodNext;
        pos   <= pos + 3'd1;
      end else begin
        timer <= timer - 1'b1;
      end

      if (strb.lenLoad) lenCnt <= wrData[5:0];
      else if (strb.lenTick && cfg.counterMode && active) begin
        lenCnt <= lenCnt + 6'd1;
        if (lenCnt == 6'd63) active <= 1'b0;
      end

      if (strb.trigger) begin
        vol      <= cfg.envInit;
        envTimer <= cfg.envPeriod;
      end else if (envFire) begin
        envTimer <= cfg.envPeriod;
        if (cfg.envUp && vol != 4'd15) vol <= vol + 4'd1;
        else if (!cfg.envUp && vol != 4'd0) vol <= vol - 4'd1;
      end else if (strb.envTick && cfg.envPeriod != 3'd0) begin
        envTimer <= envTimer - 3'd1;
      end

      if (strb.trigger) sweepTimer <= cfg.sweepTime;
      else if (sweepFire) sweepTimer <= cfg.sweepTime;
      else if (strb.sweepTick && cfg.sweepTime != 3'd0) sweepTimer <= sweepTimer - 3'd1;

      if (sweepOvf) active <= 1'b0;
      if (strb.trigger) active <= 1'b1;
    end
  end
endmodule

// File: rtl/squareVoice.sv
module squareVoice
  import sqPkg::*;
#(
  parameter int FRAME_DIV = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [3:0] amp,
  output logic       active
);
  sqStrobe_t  strb;
  sqCfg_t     cfg;
  logic [3:0] curVol;

  sqControl #(.FRAME_DIV(FRAME_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .cfg(cfg), .strb(strb)
  );

  sqDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .wrData(wrData),
    .amp(amp), .active(active), .curVol(curVol)
  );
endmodule

// File: rtl/sqChecker.sv
module sqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] regAddr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [3:0] amp,
  input logic       active,
  input logic [3:0] curVol
);
  assert_restart_sets_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 3'd4 && wrData[7]) |=> active);

  assert_silent_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (amp == 4'd0));

  assert_freq_low_unreadable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd3) |-> (rdData == 8'hFF));

  assert_duty_read_pattern_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1) |-> (rdData[5:0] == 6'h3F));

  assert_volume_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && regAddr == 3'd4 && wrData[7]) |->
      (({1'b0, curVol} == {1'b0, $past(curVol)}) ||
       ({1'b0, curVol} == {1'b0, $past(curVol)} + 5'd1) ||
       ({1'b0, curVol} + 5'd1 == {1'b0, $past(curVol)})));
endmodule

bind squareVoice sqChecker u_sqChecker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .rdData(rdData), .amp(amp), .active(active), .curVol(curVol)
);

// File: tb/tb_squareVoice.sv
module tb_squareVoice;
  localparam int CLK_PERIOD = 10;
  localparam int FDIV = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [3:0] amp;
  logic       active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  squareVoice #(.FRAME_DIV(FDIV)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .amp(amp), .active(active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int highOf(input int duty);
    case (duty)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int periodOf(input int f);
    return (2048 - f) * 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regAddr = 3'(a);
    #1 d = int'(rdData);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic maxAmp(input int n, output int m);
    m = 0;
    for (int i = 0; i < n; i++) begin
      if (int'(amp) > m) m = int'(amp);
      @(negedge clk);
    end
  endtask

  task automatic highRun(output int len);
    int guard;
    guard = 0;
    len = 0;
    while (amp != 4'd0 && guard < 60000) begin @(negedge clk); guard++; end
    while (amp == 4'd0 && guard < 60000) begin @(negedge clk); guard++; end
    while (amp != 4'd0 && guard < 60000) begin @(negedge clk); guard++; len++; end
  endtask

  task automatic trig(input int f, input int mode);
    wr(3, f & 8'hFF);
    wr(4, 8'h80 | (mode << 6) | ((f >> 8) & 7));
  endtask

  initial begin
    int v, m, f, duty, vol, sum, expSum, seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(amp == 4'd0, "R1 amp", int'(amp), 0);
    check(active == 1'b0, "R1 active", int'(active), 0);

    // R5 readback
    wr(1, 8'h80); rd(1, v); check(v == 8'hBF, "R5 duty read", v, 8'hBF);
    wr(4, 8'h47); rd(4, v); check(v == 8'hFF, "R5 freqhi read", v, 8'hFF);
    wr(4, 8'h07); rd(4, v); check(v == 8'hBF, "R5 freqhi mode0", v, 8'hBF);
    wr(3, 8'h12); rd(3, v); check(v == 8'hFF, "R5 freqlo read", v, 8'hFF);
    wr(2, 8'hA5); rd(2, v); check(v == 8'hA5, "R5 env read", v, 8'hA5);
    wr(0, 8'h2B); rd(0, v); check(v == 8'hAB, "R5 sweep read", v, 8'hAB);
    check(active == 1'b0, "R1 no start without restart bit", int'(active), 0);

    // R2 R3 R4 random duty/frequency/volume, sum over one full duty cycle
    for (int it = 0; it < 10; it++) begin
      duty = int'($urandom_range(0, 3));
      f    = 2000 + int'($urandom_range(0, 47));
      vol  = 1 + int'($urandom_range(0, 14));
      if (it == 0) begin duty = 3; f = 2047; vol = 15; end
      if (it == 1) begin duty = 0; f = 2000; vol = 1; end
      wr(0, 0);
      wr(2, vol << 4);
      wr(1, duty << 6);
      wr(3, f & 8'hFF);
      wr(4, 8'h80 | (f >> 8));
      sum = 0;
      for (int i = 0; i < 8 * periodOf(f); i++) begin
        sum += int'(amp);
        @(negedge clk);
      end
      expSum = vol * highOf(duty) * periodOf(f);
      check(sum == expSum, "R3 R4 duty/period amplitude sum", sum, expSum);
    end
    check(active == 1'b1, "R2 active after restart", int'(active), 1);

    // R6 length in counter mode
    wr(0, 0); wr(2, 8'hF0); wr(1, 8'hFC);
    trig(2047, 1);
    waitCyc(300);
    check(active == 1'b1, "R6 still running before expiry", int'(active), 1);
    waitCyc(230);
    check(active == 1'b0, "R6 stopped after length expiry", int'(active), 0);
    check(amp == 4'd0, "R3 silent after stop", int'(amp), 0);
    // R6 continuous mode
    wr(1, 8'hFC);
    trig(2047, 0);
    waitCyc(1200);
    check(active == 1'b1, "R6 continuous ignores length", int'(active), 1);

    // R7 envelope down
    wr(2, 8'hF1);
    trig(2047, 0);
    waitCyc(1280);
    maxAmp(16, m);
    check(m == 12 || m == 13, "R7 envelope decay midway", m, 13);
    waitCyc(9000);
    maxAmp(16, m);
    check(m == 0, "R7 envelope floor", m, 0);
    check(active == 1'b1, "R7 floor keeps voice active", int'(active), 1);
    // R7 up and clamp
    wr(2, 8'h09);
    trig(2047, 0);
    waitCyc(9000);
    maxAmp(16, m);
    check(m == 15, "R7 envelope ceiling", m, 15);
    // R7 period zero holds
    wr(2, 8'h90);
    trig(2047, 0);
    waitCyc(2000);
    maxAmp(16, m);
    check(m == 9, "R7 period zero holds volume", m, 9);

    // R8 sweep overflow on first step
    wr(2, 8'hF0);
    wr(0, 8'h11);
    trig(1800, 0);
    check(active == 1'b1, "R8 active at restart", int'(active), 1);
    waitCyc(260);
    check(active == 1'b0, "R8 overflow stops voice", int'(active), 0);
    // R8 overflow only on second step
    trig(1024, 0);
    waitCyc(250);
    check(active == 1'b1, "R8 first step in range", int'(active), 1);
    waitCyc(270);
    check(active == 1'b0, "R8 second step overflows", int'(active), 0);

    // R9 shift zero leaves frequency
    wr(1, 8'h80);
    wr(0, 8'h18);
    trig(2044, 0);
    waitCyc(600);
    highRun(m);
    check(m == 4 * periodOf(2044), "R9 shift zero unchanged", m, 4 * periodOf(2044));
    // R9 decrease by one sweep, then time zero
    wr(0, 8'h79);
    trig(2044, 0);
    waitCyc(1800);
    wr(0, 8'h09);
    highRun(m);
    check(m == 4 * periodOf(1022), "R9 decrease result", m, 4 * periodOf(1022));
    check(active == 1'b1, "R9 decrease keeps voice", int'(active), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule